// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Packed Status Flags

This block is the purely combinational datapath of a small accumulator machine. It takes the accumulator value, a second operand, the current carry flag and a four-bit operation code. It returns an eight-bit result and a status byte in one evaluation.

The status byte always has the same bit layout, so a surrounding register stage can capture it directly as the processor's flag register. The byte carries sign, zero, half-carry, even parity and carry. Carry reads as borrow after a subtraction. Increment and decrement pass the incoming carry flag through unchanged. The logical operations clear it.

Top module: `status_alu`

## Requirements
- R1: `flags_out` layout: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity, bit 0 carry. Bits 5, 3 and 1 are always 0.
- R2: The sign flag equals bit 7 of `result_out`.
- R3: The zero flag is 1 exactly when `result_out` is 0x00, for every operation including increment and decrement.
- R4: Code 0 (add) gives acc+opnd. Code 1 (add with carry) gives acc+opnd+carry_in. In both, carry is the carry out of bit 7. Example: 0xB5+0x6C gives 0x21 with carry=1 and half-carry=1. Example: 0xB3+0x4D gives 0x00 with zero=1 and carry=1.
- R5: The parity flag is 1 when `result_out` has an even number of ones and 0 when that number is odd.
- R6: Half-carry is the carry from bit 3 into bit 4 of the internal addition.
  - Subtract, subtract with borrow and decrement are formed by adding the complemented operand, and half-carry comes from that addition.
  - Half-carry is 0 for logical and reserved codes.
- R7: Code 2 (subtract) gives acc-opnd. Code 3 (subtract with borrow) gives acc-opnd-carry_in. Both wrap modulo 256, and carry is 1 exactly when a borrow occurs.
- R8: Codes 4, 5 and 6 give bitwise AND, OR and XOR of the operands, and carry is 0.
- R9: Code 7 (increment) gives acc+1. Code 8 (decrement) gives acc-1. Both wrap modulo 256, and carry equals `carry_in`.
- R10: Codes 9 to 15 are reserved. They return `acc_in` unchanged with carry 0 and half-carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag, used by add with carry, subtract with borrow, increment and decrement |
| result_out | output | 8 | Operation result |
| flags_out | output | 8 | Packed status byte |

## Verification
The checks sample the outputs only when no input carries an unknown value. Each check is therefore guarded to skip while any input is X, which covers the time before the bench first drives them.

The bench holds each input set stable for a full clock period. It compares the outputs half a period later, after the combinational paths have settled. The stimulus sweeps every operation code, including the reserved ones. It uses both values of the carry input and operands chosen to hit wrap-around, nibble carries, zero results and both parities.

// File: rtl/status_alu_pkg.sv
// Package: shared operation codes and flag-bit positions for the ALU.
// Assumes an 8-bit status byte whose layout is fixed by the requirements.
package status_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8
    } alu_op_e;

    localparam int FLAG_W      = 8;
    localparam int FLG_SIGN    = 7;
    localparam int FLG_ZERO    = 6;
    localparam int FLG_HALF    = 4;
    localparam int FLG_PARITY  = 2;
    localparam int FLG_CARRY   = 0;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_PASS  = 2'd2
    } op_class_e;
endpackage

// File: rtl/status_alu_adder.sv
// Module: ripple adder with a tap on the carry leaving the lower half.
// Assumes HALF_POS lies strictly inside the word.
module status_alu_adder #(
    parameter int DATA_W   = 8,
    parameter int HALF_POS = 4
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              half_c_out,
    output logic              c_out
);
    logic [DATA_W:0] chain;

    assign chain[0] = c_in;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        assign sum_out[i]  = a_in[i] ^ b_in[i] ^ chain[i];
        assign chain[i+1]  = (a_in[i] & b_in[i]) | (chain[i] & (a_in[i] ^ b_in[i]));
    end

    assign half_c_out = chain[HALF_POS];
    assign c_out      = chain[DATA_W];
endmodule

// File: rtl/status_alu_logic.sv
// Module: bitwise AND/OR/XOR unit selected by a two-bit code.
// Assumes the caller ignores the output for non-logical operations.
module status_alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        fn_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] y_out
);
    // Select the bitwise function.
    always_comb begin
        unique case (fn_sel)
            2'd0:    y_out = a_in & b_in;
            2'd1:    y_out = a_in | b_in;
            2'd2:    y_out = a_in ^ b_in;
            default: y_out = '0;
        endcase
    end
endmodule

// File: rtl/status_alu_flags.sv
// Module: packs sign, zero, half-carry, parity and carry into the status byte.
// Assumes half-carry and carry arrive already resolved for the operation.
module status_alu_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_in,
    input  logic              half_in,
    input  logic              carry_in,
    output logic [7:0]        flags_out
);
    import status_alu_pkg::*;

    // Build the byte with the unused bits held at zero.
    always_comb begin
        flags_out             = '0;
        flags_out[FLG_SIGN]   = res_in[DATA_W-1];
        flags_out[FLG_ZERO]   = (res_in == '0);
        flags_out[FLG_HALF]   = half_in;
        flags_out[FLG_PARITY] = ~^res_in;
        flags_out[FLG_CARRY]  = carry_in;
    end
endmodule

// File: rtl/status_alu.sv
// Module: top of the eight-bit ALU with packed status flags.
// Assumes a purely combinational use; the caller registers the outputs.
module status_alu #(
    parameter int DATA_W   = 8,
    parameter int HALF_POS = 4
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result_out,
    output logic [7:0]        flags_out
);
    import status_alu_pkg::*;

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic              sub_mode;
    logic              keep_carry;
    op_class_e         op_cls;
    logic [1:0]        log_fn;
    logic [DATA_W-1:0] add_sum;
    logic              add_half;
    logic              add_cout;
    logic [DATA_W-1:0] log_y;
    logic              half_fin;
    logic              carry_fin;

    // Decode the operation into adder operands and result class.
    always_comb begin
        add_b      = '0;
        add_cin    = 1'b0;
        sub_mode   = 1'b0;
        keep_carry = 1'b0;
        op_cls     = CLS_PASS;
        log_fn     = 2'd3;
        case (op_sel)
            OP_ADD: begin add_b = opnd_in;  op_cls = CLS_ARITH; end
            OP_ADC: begin add_b = opnd_in;  add_cin = carry_in; op_cls = CLS_ARITH; end
            OP_SUB: begin add_b = ~opnd_in; add_cin = 1'b1; sub_mode = 1'b1; op_cls = CLS_ARITH; end
            OP_SBB: begin add_b = ~opnd_in; add_cin = ~carry_in; sub_mode = 1'b1; op_cls = CLS_ARITH; end
            OP_AND: begin op_cls = CLS_LOGIC; log_fn = 2'd0; end
            OP_OR:  begin op_cls = CLS_LOGIC; log_fn = 2'd1; end
            OP_XOR: begin op_cls = CLS_LOGIC; log_fn = 2'd2; end
            OP_INC: begin add_cin = 1'b1; keep_carry = 1'b1; op_cls = CLS_ARITH; end
            OP_DEC: begin add_b = '1; keep_carry = 1'b1; op_cls = CLS_ARITH; end
            default: ;
        endcase
    end

    status_alu_adder #(.DATA_W(DATA_W), .HALF_POS(HALF_POS)) u_add (
        .a_in      (acc_in),
        .b_in      (add_b),
        .c_in      (add_cin),
        .sum_out   (add_sum),
        .half_c_out(add_half),
        .c_out     (add_cout)
    );

    status_alu_logic #(.DATA_W(DATA_W)) u_log (
        .fn_sel(log_fn),
        .a_in  (acc_in),
        .b_in  (opnd_in),
        .y_out (log_y)
    );

    // Pick the result and resolve half-carry and carry for its class.
    always_comb begin
        result_out = acc_in;
        half_fin   = 1'b0;
        carry_fin  = 1'b0;
        unique case (op_cls)
            CLS_ARITH: begin
                result_out = add_sum;
                half_fin   = add_half;
                carry_fin  = keep_carry ? carry_in : (add_cout ^ sub_mode);
            end
            CLS_LOGIC: result_out = log_y;
            default:   result_out = acc_in;
        endcase
    end

    status_alu_flags #(.DATA_W(DATA_W)) u_flg (
        .res_in   (result_out),
        .half_in  (half_fin),
        .carry_in (carry_fin),
        .flags_out(flags_out)
    );
endmodule

// File: rtl/status_alu_chk.sv
// Module: checker for the ALU outputs, attached with bind.
// Assumes inputs may be unknown before first drive; checks skip then.
module status_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic [DATA_W-1:0] result_out,
    input logic [7:0]        flags_out
);
    logic known;
    assign known = !$isunknown({op_sel, acc_in, opnd_in, carry_in});

    // Check flag relations whenever the inputs are defined.
    always_comb begin
        if (known) begin
            AST_SIGN_MATCH: assert (flags_out[7] == result_out[DATA_W-1]); // R2
            AST_ZERO_MATCH: assert (flags_out[6] == (result_out == '0)); // R3
            AST_HOLES_ZERO: assert (flags_out[5] == 1'b0 && flags_out[3] == 1'b0 && flags_out[1] == 1'b0); // R1
            AST_PARITY_EVEN: assert (flags_out[2] == ~^result_out); // R5
            AST_LOGIC_CLEARS_CY: assert (!(op_sel inside {4'd4, 4'd5, 4'd6}) || flags_out[0] == 1'b0); // R8
            AST_INCDEC_KEEPS_CY: assert (!(op_sel inside {4'd7, 4'd8}) || flags_out[0] == carry_in); // R9
            AST_RESERVED_PASS: assert (op_sel < 4'd9 || (result_out == acc_in && flags_out[0] == 1'b0 && flags_out[4] == 1'b0)); // R10
        end
    end
endmodule

bind status_alu status_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .carry_in  (carry_in),
    .result_out(result_out),
    .flags_out (flags_out)
);

// File: tb/sim_status_alu.sv
// Bench: scoreboard for the ALU; driver queues expectations, monitor compares.
module sim_status_alu;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      tag;
        logic [3:0] op;
        logic [7:0] res;
        logic [7:0] flg;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result_out;
    logic [7:0] flags_out;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    status_alu u0 (
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .carry_in  (carry_in),
        .result_out(result_out),
        .flags_out (flags_out)
    );

    // Free-running clock for pacing.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic void model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input logic c,
                                  output logic [7:0] r, output logic [7:0] f);
        int s;
        logic ac;
        logic cy;
        ac = 1'b0;
        cy = 1'b0;
        case (op)
            4'd0: begin s = a + b; cy = s[8]; ac = ((a & 15) + (b & 15)) > 15; end
            4'd1: begin s = a + b + c; cy = s[8]; ac = ((a & 15) + (b & 15) + c) > 15; end
            4'd2: begin s = a - b; cy = (a < b); ac = ((a & 15) + (~b & 15) + 1) > 15; end
            4'd3: begin s = a - b - c; cy = (a < b + c); ac = ((a & 15) + (~b & 15) + (1 - c)) > 15; end
            4'd4: s = a & b;
            4'd5: s = a | b;
            4'd6: s = a ^ b;
            4'd7: begin s = a + 1; cy = c; ac = (a & 15) == 15; end
            4'd8: begin s = a - 1; cy = c; ac = (a & 15) != 0; end
            default: s = a;
        endcase
        r = s[7:0];
        f = {r[7], r == 8'h00, 1'b0, ac, 1'b0, ~^r, 1'b0, cy};
    endfunction

    // Driver: apply one input set and queue its expectation.
    task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic c);
        exp_t e;
        @(posedge clk);
        op_sel = op; acc_in = a; opnd_in = b; carry_in = c;
        e.tag = tag; e.op = op;
        model(op, a, b, c, e.res, e.flg);
        sb.push_back(e);
    endtask

    // Driver: queue an explicitly stated expectation.
    task automatic apply_fixed(input string tag, input logic [3:0] op, input logic [7:0] a,
                               input logic [7:0] b, input logic c,
                               input logic [7:0] r, input logic [7:0] f);
        exp_t e;
        @(posedge clk);
        op_sel = op; acc_in = a; opnd_in = b; carry_in = c;
        e.tag = tag; e.op = op; e.res = r; e.flg = f;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs half a period after each drive.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (result_out !== e.res || flags_out !== e.flg) begin
                n_fail++;
                $display("FAIL %s op=%0d: got res=%02h flags=%08b, expected res=%02h flags=%08b",
                         e.tag, e.op, result_out, flags_out, e.res, e.flg);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        logic [7:0] pat [8];
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h0F; pat[3] = 8'hF0;
        pat[4] = 8'h80; pat[5] = 8'h7F; pat[6] = 8'hB5; pat[7] = 8'h01;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1 R3 R5: all-zero input after reset gives zero and parity only.
        apply_fixed("R1_reset_state", 4'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'b0100_0100);
        // R4 R6: stated sums.
        apply_fixed("R4_R6_b5_6c", 4'd0, 8'hB5, 8'h6C, 1'b0, 8'h21, 8'b0001_0101);
        apply_fixed("R3_R4_b3_4d", 4'd0, 8'hB3, 8'h4D, 1'b0, 8'h00, 8'b0101_0101);
        apply_fixed("R4_adc", 4'd1, 8'h0E, 8'h01, 1'b1, 8'h10, 8'b0001_0000);
        // R7: borrow and wrap.
        apply_fixed("R7_borrow", 4'd2, 8'h00, 8'h01, 1'b0, 8'hFF, 8'b1000_0101);
        apply_fixed("R7_sbb", 4'd3, 8'h05, 8'h05, 1'b1, 8'hFF, 8'b1000_0101);
        // R2 R5: sign and odd parity.
        apply_fixed("R2_R5_sign", 4'd5, 8'h80, 8'h00, 1'b1, 8'h80, 8'b1000_0000);
        // R9: wrap and carry pass-through.
        apply_fixed("R9_inc_wrap", 4'd7, 8'hFF, 8'h00, 1'b0, 8'h00, 8'b0101_0100);
        apply_fixed("R9_dec_wrap", 4'd8, 8'h00, 8'h00, 1'b1, 8'hFF, 8'b1000_0101);
        // R6: nibble carry on increment.
        apply_fixed("R6_inc_half", 4'd7, 8'h0F, 8'h00, 1'b0, 8'h10, 8'b0001_0000);
        // R8: logic clears carry.
        apply_fixed("R8_xor", 4'd6, 8'hF0, 8'h0F, 1'b1, 8'hFF, 8'b1000_0100);
        // R10: reserved code passes accumulator.
        apply_fixed("R10_reserved", 4'd12, 8'h3C, 8'hFF, 1'b1, 8'h3C, 8'b0000_0100);
        // Sweep every code with pattern pairs and both carries.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j += 3) begin
                    for (int c = 0; c < 2; c++) begin
                        string t;
                        t = (op < 2) ? "R4_sweep" : (op < 4) ? "R7_sweep" :
                            (op < 7) ? "R8_sweep" : (op < 9) ? "R9_sweep" : "R10_sweep";
                        apply(t, op[3:0], pat[i], pat[j], c[0]);
                    end
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule